// File: doc/BRIEF.md
# Power-management interrupt event aggregator

This block gathers four kinds of power-management event and turns them into one of two level requests: a system control interrupt (SCI) for the operating system's power handler, or a system management interrupt (SMI) for firmware. The sources are a free-running power-management timer that flags each time its top bit toggles, an edge on an asynchronous thermal input, a release flag that firmware sets by a register write, and a set of general-purpose inputs. Each source has a status bit and an enable bit. Status bits for the timer, thermal and release sources are sticky and cleared by writing one. The general-purpose status is a live view of the qualified inputs. It falls only when the device driving the input lets go.

A global routing bit picks the target. When it is set, every enabled pending source drives the SCI level. When it is clear, enabled timer and thermal events drive the SMI level instead, and the release and general-purpose sources request nothing. Both outputs are registered, active high, and stay high until every enabled pending source that feeds them is gone. Software reaches the block through a small single-cycle register port with a two-bit address and a combinational read path.

Top module: `pm_event_agg`

## Requirements
- R1: After reset, reads of all four addresses return 0 and both `sci_o` and `smi_o` are low.
- R2: With a timer of width TMR_W, the timer status (status bit 0) sets on the 2^(TMR_W-1)th `tmr_tick` pulse after reset and again after each further 2^(TMR_W-1) pulses. Clock cycles without `tmr_tick` do not advance the timer.
- R3: Config bit 1 selects the thermal edge: 0 for rising and 1 for falling. Only the selected edge of `thrm_pin` sets status bit 1, and the opposite edge leaves it unchanged.
- R4: Writing config with bit 2 set raises status bit 2, and config bit 2 always reads 0. Writing a one to status bit 2 clears it.
- R5: Status bit 3 reads 1 exactly when some `gpio_in` bit is high and its direction bit (address 3, 1 = input) is set. Writing a one to status bit 3 does not clear it.
- R6: Status bits 0 to 2 are sticky. A status write clears only the bits written as 1, and an event that arrives in the same cycle as the clearing write leaves the bit set.
- R7: While config bit 0 is 1, `sci_o` rises one cycle after any source has both its status and its enable set. It stays high until no such source remains.
- R8: While config bit 0 is 0, `smi_o` is high one cycle after an enabled timer or thermal status is pending, and `sci_o` stays low. Release and general-purpose status request nothing in this case.
- R9: Status bits set whether or not the source is enabled. A disabled source drives neither output.
- R10: Register map: address 0 is status (read, write-one-to-clear, bits 3:0), address 1 is enable (bits 3:0, bit order as status), address 2 is config (bit 0 routes to SCI, bit 1 selects the falling edge, bit 2 is the release trigger), and address 3 is the input direction mask. Enable and direction read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_tick | input | 1 | Timer advance strobe, one pulse per timer count |
| thrm_pin | input | 1 | Asynchronous thermal event input |
| gpio_in | input | N_GPIO | Asynchronous general-purpose inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| sci_o | output | 1 | Level system control interrupt request |
| smi_o | output | 1 | Level system management interrupt request |

## Verification
The bench counts timer strobes up to one short of the overflow point and confirms there is no status, then one past it. It issues a clearing write in the same cycle as an overflow, so a design that lets the clear win loses that event. It drives both thermal edges under each polarity setting, which catches a detector tied to one edge or one that fires on both. It tries to clear the live general-purpose status and flips the routing bit while events are pending, which exposes a design that sends release or general-purpose events to SMI, or that raises both outputs at once.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int SRC_N    = 4;
  localparam int SRC_TMR  = 0;
  localparam int SRC_THRM = 1;
  localparam int SRC_REL  = 2;
  localparam int SRC_GPIO = 3;

  localparam int CFG_SCI  = 0;
  localparam int CFG_FALL = 1;
  localparam int CFG_REL  = 2;

  typedef enum logic [1:0] {
    A_STS = 2'd0,
    A_ENA = 2'd1,
    A_CFG = 2'd2,
    A_DIR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pm_acpi_timer.sv
module pm_acpi_timer #(
  parameter int TMR_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic ovf
);
  localparam int LOW_W = TMR_W - 1;

  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  // top bit toggles when every lower bit is one and the count advances
  assign ovf = tick && (&cnt_q[LOW_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r2_msb_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q[TMR_W-1] != $past(cnt_q[TMR_W-1])));

  a_r2_msb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(cnt_q[TMR_W-1]));
endmodule

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pm_edge_det.sv
module pm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic fall_sel,
  output logic hit
);
  logic prev_q;

  always_comb begin
    if (fall_sel) hit = prev_q && !lvl;
    else          hit = !prev_q && lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  a_r3_hit_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/pm_event_agg.sv
module pm_event_agg
  import pm_evt_pkg::*;
#(
  parameter int TMR_W   = 24,
  parameter int N_GPIO  = 8,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic              thrm_pin,
  input  logic [N_GPIO-1:0] gpio_in,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              sci_o,
  output logic              smi_o
);
  localparam int STICKY_N = SRC_N - 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // event sources
  logic tmr_ovf, thrm_lvl, thrm_hit;
  logic [N_GPIO-1:0] gpio_lvl;

  pm_acpi_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_q), .tick(tmr_tick), .ovf(tmr_ovf));

  pm_sync #(.W(1), .STAGES(SYNC_ST)) u_thrm_sync (
    .clk(clk), .rst_n(rst_q), .d(thrm_pin), .q(thrm_lvl));

  pm_sync #(.W(N_GPIO), .STAGES(SYNC_ST)) u_gpio_sync (
    .clk(clk), .rst_n(rst_q), .d(gpio_in), .q(gpio_lvl));

  // registers
  logic [STICKY_N-1:0] sts_q, sts_d, sts_set, sts_clr;
  logic [SRC_N-1:0]    ena_q, ena_d, sts_view, pend;
  logic [1:0]          cfg_q, cfg_d;
  logic [N_GPIO-1:0]   dir_q, dir_d;
  logic                sci_d, smi_d, rel_set;
  logic                wr_sts, wr_ena, wr_cfg, wr_dir;

  pm_edge_det u_thrm_edge (
    .clk(clk), .rst_n(rst_q), .lvl(thrm_lvl),
    .fall_sel(cfg_q[CFG_FALL]), .hit(thrm_hit));

  always_comb begin
    wr_sts = wr_en && (addr == A_STS);
    wr_ena = wr_en && (addr == A_ENA);
    wr_cfg = wr_en && (addr == A_CFG);
    wr_dir = wr_en && (addr == A_DIR);
  end

  assign rel_set = wr_cfg && wr_data[CFG_REL];

  always_comb begin
    sts_set           = '0;
    sts_set[SRC_TMR]  = tmr_ovf;
    sts_set[SRC_THRM] = thrm_hit;
    sts_set[SRC_REL]  = rel_set;
    sts_clr           = wr_sts ? wr_data[STICKY_N-1:0] : '0;
    // a new event outranks a clear in the same cycle
    sts_d             = (sts_q & ~sts_clr) | sts_set;
  end

  always_comb begin
    ena_d = wr_ena ? wr_data[SRC_N-1:0] : ena_q;
    cfg_d = wr_cfg ? wr_data[CFG_FALL:CFG_SCI] : cfg_q;
    dir_d = wr_dir ? wr_data[N_GPIO-1:0] : dir_q;
  end

  always_comb begin
    sts_view = {|(gpio_lvl & dir_q), sts_q};
    pend     = sts_view & ena_q;
    sci_d    = cfg_q[CFG_SCI] && (|pend);
    smi_d    = !cfg_q[CFG_SCI] && (pend[SRC_TMR] || pend[SRC_THRM]);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sts_q <= '0;
      ena_q <= '0;
      cfg_q <= '0;
      dir_q <= '0;
      sci_o <= 1'b0;
      smi_o <= 1'b0;
    end else begin
      sts_q <= sts_d;
      ena_q <= ena_d;
      cfg_q <= cfg_d;
      dir_q <= dir_d;
      sci_o <= sci_d;
      smi_o <= smi_d;
    end
  end

  // read path
  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_STS: rd_data[SRC_N-1:0]  = sts_view;
      A_ENA: rd_data[SRC_N-1:0]  = ena_q;
      A_CFG: rd_data[1:0]        = cfg_q;
      A_DIR: rd_data[N_GPIO-1:0] = dir_q;
      default: rd_data = '0;
    endcase
  end

  a_r6_tmr_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (sts_q[SRC_TMR] && !sts_clr[SRC_TMR]) |=> sts_q[SRC_TMR]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_q)
    tmr_ovf |=> sts_q[SRC_TMR]);

  a_r4_rel_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (sts_q[SRC_REL] && !sts_clr[SRC_REL]) |=> sts_q[SRC_REL]);

  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_q)
    !(sci_o && smi_o));

  a_r8_no_smi_when_sci: assert property (@(posedge clk) disable iff (!rst_q)
    cfg_q[CFG_SCI] |=> !smi_o);

  a_r7_sci_follows: assert property (@(posedge clk) disable iff (!rst_q)
    (cfg_q[CFG_SCI] && (|pend)) |=> sci_o);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (pend == '0) |=> (!sci_o && !smi_o));
endmodule

// File: tb/tb_pm_event_agg.sv
module tb_pm_event_agg;
  localparam int TW = 6;
  localparam int NG = 8;
  localparam int HALF = 1 << (TW - 1);

  logic clk, rst_n, tmr_tick, thrm_pin, wr_en, sci_o, smi_o;
  logic [NG-1:0] gpio_in;
  logic [1:0] addr;
  logic [7:0] wr_data, rd_data;
  int errs = 0;
  int checks = 0;

  pm_event_agg #(.TMR_W(TW), .N_GPIO(NG)) dut (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .thrm_pin(thrm_pin),
    .gpio_in(gpio_in), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sci_o(sci_o), .smi_o(smi_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmr_tick = 1'b1;
      @(negedge clk); tmr_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", d, 8'h00);
    end
    chk("R1 reset sci", {7'd0, sci_o}, 8'h00);
    chk("R1 reset smi", {7'd0, smi_o}, 8'h00);
  endtask

  task automatic t_timer;
    logic [7:0] d;
    ticks(HALF - 1);
    idle(3);
    rd(2'd0, d); chk("R2 no overflow before limit", d & 8'h01, 8'h00);
    ticks(1);
    rd(2'd0, d); chk("R2 overflow at limit", d & 8'h01, 8'h01);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h01);
    idle(1);
    chk("R7 sci on timer", {7'd0, sci_o}, 8'h01);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R6 zero write keeps status", d & 8'h01, 8'h01);
    wr(2'd0, 8'h01);
    rd(2'd0, d); chk("R6 w1c clears timer", d & 8'h01, 8'h00);
    idle(1);
    chk("R7 sci drops after clear", {7'd0, sci_o}, 8'h00);
    ticks(HALF - 1);
    @(negedge clk);
    tmr_tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wr_data = 8'h01;
    @(negedge clk);
    tmr_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd(2'd0, d); chk("R6 event beats clear", d & 8'h01, 8'h01);
    chk("R2 second overflow on falling top bit", d & 8'h01, 8'h01);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_thermal;
    logic [7:0] d;
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h02);
    thrm_pin = 1'b1; idle(5);
    rd(2'd0, d); chk("R3 rising edge sets", d & 8'h02, 8'h02);
    chk("R7 sci on thermal", {7'd0, sci_o}, 8'h01);
    wr(2'd0, 8'h02);
    thrm_pin = 1'b0; idle(5);
    rd(2'd0, d); chk("R3 falling ignored in rising mode", d & 8'h02, 8'h00);
    wr(2'd2, 8'h03);
    thrm_pin = 1'b1; idle(5);
    rd(2'd0, d); chk("R3 rising ignored in falling mode", d & 8'h02, 8'h00);
    thrm_pin = 1'b0; idle(5);
    rd(2'd0, d); chk("R3 falling edge sets", d & 8'h02, 8'h02);
    wr(2'd2, 8'h02);
    idle(1);
    chk("R8 smi when routed away", {7'd0, smi_o}, 8'h01);
    chk("R8 sci low when routed away", {7'd0, sci_o}, 8'h00);
    wr(2'd1, 8'h00);
    idle(1);
    chk("R9 disabled source quiet", {6'd0, smi_o, sci_o}, 8'h00);
    rd(2'd0, d); chk("R9 status kept while disabled", d & 8'h02, 8'h02);
    wr(2'd0, 8'h02);
  endtask

  task automatic t_release;
    logic [7:0] d;
    wr(2'd2, 8'h05);
    rd(2'd0, d); chk("R4 release set", d & 8'h04, 8'h04);
    rd(2'd2, d); chk("R4 release reads 0 in config", d, 8'h01);
    wr(2'd1, 8'h04);
    idle(1);
    chk("R7 sci on release", {7'd0, sci_o}, 8'h01);
    wr(2'd2, 8'h00);
    idle(1);
    chk("R8 release no smi", {6'd0, smi_o, sci_o}, 8'h00);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R4 release cleared", d & 8'h04, 8'h00);
  endtask

  task automatic t_gpio;
    logic [7:0] d;
    gpio_in = 8'h02; idle(4);
    rd(2'd0, d); chk("R5 non-input ignored", d & 8'h08, 8'h00);
    wr(2'd3, 8'h02);
    rd(2'd3, d); chk("R10 direction readback", d, 8'h02);
    rd(2'd0, d); chk("R5 qualified input sets", d & 8'h08, 8'h08);
    wr(2'd1, 8'h08);
    idle(1);
    chk("R8 gpio no smi", {6'd0, smi_o, sci_o}, 8'h00);
    wr(2'd0, 8'h08);
    rd(2'd0, d); chk("R5 write cannot clear", d & 8'h08, 8'h08);
    wr(2'd2, 8'h01);
    idle(1);
    chk("R7 sci on gpio", {7'd0, sci_o}, 8'h01);
    rd(2'd1, d); chk("R10 enable readback", d, 8'h08);
    gpio_in = 8'h00; idle(4);
    rd(2'd0, d); chk("R5 follows device", d & 8'h08, 8'h00);
    chk("R7 sci drops when source gone", {7'd0, sci_o}, 8'h00);
  endtask

  initial begin
    #4000000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tmr_tick = 1'b0; thrm_pin = 1'b0; gpio_in = '0;
    wr_en = 1'b0; addr = '0; wr_data = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_timer;
    t_thermal;
    t_release;
    t_gpio;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule